// File: doc/BRIEF.md
# Carrier Local-Space Address Decoder

This block sits behind the host front end of a four-slot module carrier. Each host request names a local window, a byte address, an access size and, for writes, data. The block splits the address into a slot number, a sub-space and an offset, and presents the access for one cycle on a generic per-slot module bus. A slot that has no module installed is never strobed, and reads aimed at it return zero.

There are four windows. The register window is 1 KiB and is divided per slot into I/O, ID and interrupt sub-spaces. The 16-bit memory window gives each slot 8 MiB. The 8-bit memory window gives each slot 4 MiB. The configuration window holds three big-endian flags. The flags can be set independently for a control-register window that sits outside this block, for the register window and for the 16-bit memory window. When a window's flag is set, byte accesses have address bit 0 inverted and halfword accesses have their two data bytes exchanged in both directions. The 8-bit memory window is never corrected.

The host port is a single-cycle request. Strobes are combinational during the request cycle. The acknowledge and the read data are registered and appear one cycle later.

Top module: `carrier_addr_dec`

## Requirements
- R1: After reset all three endian flags are clear (little-endian), `ack_o` is 0 and `rdata_o` is 0.
- R2: In the register window (`win_i`=1), the slot is addr[9:8] and the sub-space is addr[7:6]. Sub-space 2 selects ID (`space_sel_o` bit 1) with offset addr[5:0]. Sub-space 3 selects interrupt (bit 2) with offset addr[5:0]. Sub-spaces 0 and 1 select I/O (bit 0) with offset addr[6:0].
- R3: In the 16-bit memory window (`win_i`=2), the slot is addr[24:23], the offset is addr[22:0] and `space_sel_o` bit 3 is set. In the 8-bit memory window (`win_i`=3), the slot is addr[23:22], the offset is addr[21:0], `space_sel_o` bit 4 is set and addr[24] is ignored.
- R4: An access to a present slot drives `slot_sel_o` one-hot (bit = slot number) and `space_sel_o` one-hot, only in the cycle `req_i` is high. `mod_we_o` follows `we_i` and `mod_wdata_o` carries the write data.
- R5: An access to a slot whose `present_i` bit is 0 produces no strobe and no module write, and a read of it returns 0.
- R6: Every request is acknowledged by `ack_o` exactly one cycle later. In that cycle `rdata_o` holds the read result: `mod_rdata_i` as sampled in the request cycle, after any byte correction. After a write, `rdata_o` is 0.
- R7: With the window's flag set, a byte access (`size2_i`=0) to the register window or the 16-bit memory window inverts address bit 0 before decoding.
- R8: With the window's flag set, a halfword access (`size2_i`=1) to those windows exchanges the two bytes of the write data towards the module and of the read data towards the host. `mod_size2_o` is 1.
- R9: The 8-bit memory window never applies endian correction, whatever the flags are. It always forwards a byte access: `mod_size2_o`=0, with data and address bit 0 unchanged.
- R10: In the configuration window (`win_i`=0, byte address addr[6:0]), writes to bytes 0x2B, 0x2F and 0x33 load bit 0 of the data into the flag for the control-register window, the register window and the 16-bit memory window respectively. Reads of those bytes return 0xD4, 0x14 and 0x14 ORed with the flag. Other bytes read 0 and ignore writes, and no module is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle access request |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 2 | Window: 0 config, 1 register, 2 16-bit memory, 3 8-bit memory |
| addr_i | input | 25 | Byte address within the window |
| size2_i | input | 1 | 1 = two-byte access, 0 = one byte |
| wdata_i | input | 16 | Write data |
| ack_o | output | 1 | Acknowledge, one cycle after the request |
| rdata_o | output | 16 | Read data, valid with ack_o |
| present_i | input | 4 | Per-slot module-installed flags |
| slot_sel_o | output | 4 | One-hot slot strobe |
| space_sel_o | output | 5 | One-hot space strobe: I/O, ID, INT, MEM16, MEM8 |
| mod_we_o | output | 1 | Module-bus write |
| mod_size2_o | output | 1 | Module-bus two-byte access |
| mod_off_o | output | 23 | Offset within the selected space |
| mod_wdata_o | output | 16 | Module-bus write data, byte-corrected |
| mod_rdata_i | input | 16 | Module-bus read data, valid in the strobe cycle |

## Verification
The hardest conditions to reach combine an endian flag with a window and an access size. A byte flip must land on a different sub-space offset, and a byte swap must show up in both directions. The bench first sets the flags through configuration writes and confirms them by reading them back. It then issues byte and halfword accesses to each window. It also checks that a flag set on one window leaves the others uncorrected, including the 8-bit window with every flag set. Absent slots are exercised by clearing one `present_i` bit and then reading and writing exactly that slot.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  typedef enum logic [1:0] {
    WIN_CFG   = 2'd0,
    WIN_REGS  = 2'd1,
    WIN_MEM16 = 2'd2,
    WIN_MEM8  = 2'd3
  } win_t;

  localparam int N_SPACES = 5;
  localparam int SP_IO    = 0;
  localparam int SP_ID    = 1;
  localparam int SP_INT   = 2;
  localparam int SP_MEM16 = 3;
  localparam int SP_MEM8  = 4;

  localparam int IO_OFF_W  = 7;
  localparam int SUB_OFF_W = 6;
endpackage

// File: rtl/carrier_endian_cfg.sv
module carrier_endian_cfg #(
  parameter int          N_FLAGS     = 3,
  parameter int          CFG_AW      = 7,
  parameter int          FLAG_BASE   = 'h2B,
  parameter int          FLAG_STRIDE = 4,
  parameter logic [23:0] DEFAULTS    = 24'h14_14_D4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic              wbit_i,
  output logic [N_FLAGS-1:0] flags_o,
  output logic [7:0]        rbyte_o
);
  logic [N_FLAGS-1:0] hit;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    localparam logic [CFG_AW-1:0] FADDR = CFG_AW'(FLAG_BASE + g * FLAG_STRIDE);
    assign hit[g] = (addr_i == FADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             flags_o[g] <= 1'b0;
      else if (wr_i && hit[g]) flags_o[g] <= wbit_i;
    end
  end

  always_comb begin
    rbyte_o = '0;
    for (int i = 0; i < N_FLAGS; i++)
      if (hit[i]) rbyte_o = DEFAULTS[i*8 +: 8] | {7'd0, flags_o[i]};
  end
endmodule

// File: rtl/carrier_win_decode.sv
module carrier_win_decode
  import carrier_pkg::*;
#(
  parameter int SLOT_W       = 2,
  parameter int M16_OFF_W    = 23,
  parameter int M8_OFF_W     = 22,
  parameter int REG_SLOT_LSB = 8,
  localparam int AW          = M16_OFF_W + SLOT_W
) (
  input  win_t                 win_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 size2_i,
  input  logic                 be_regs_i,
  input  logic                 be_m16_i,
  output logic                 is_mod_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic [N_SPACES-1:0]  space_o,
  output logic [M16_OFF_W-1:0] off_o,
  output logic                 swap_o,
  output logic                 size2_o
);
  logic          be;
  logic [AW-1:0] a;
  logic [1:0]    sub;

  always_comb begin
    be = (win_i == WIN_REGS && be_regs_i) || (win_i == WIN_MEM16 && be_m16_i);
    a  = addr_i;
    if (be && !size2_i) a[0] = ~a[0];
    sub      = a[REG_SLOT_LSB-1 -: 2];
    is_mod_o = 1'b0;
    slot_o   = '0;
    space_o  = '0;
    off_o    = '0;
    unique case (win_i)
      WIN_REGS: begin
        is_mod_o = 1'b1;
        slot_o   = a[REG_SLOT_LSB +: SLOT_W];
        unique case (sub)
          2'd2: begin
            space_o[SP_ID] = 1'b1;
            off_o[SUB_OFF_W-1:0] = a[SUB_OFF_W-1:0];
          end
          2'd3: begin
            space_o[SP_INT] = 1'b1;
            off_o[SUB_OFF_W-1:0] = a[SUB_OFF_W-1:0];
          end
          default: begin
            space_o[SP_IO] = 1'b1;
            off_o[IO_OFF_W-1:0] = a[IO_OFF_W-1:0];
          end
        endcase
      end
      WIN_MEM16: begin
        is_mod_o          = 1'b1;
        slot_o            = a[M16_OFF_W +: SLOT_W];
        space_o[SP_MEM16] = 1'b1;
        off_o             = a[M16_OFF_W-1:0];
      end
      WIN_MEM8: begin
        is_mod_o               = 1'b1;
        slot_o                 = addr_i[M8_OFF_W +: SLOT_W];
        space_o[SP_MEM8]       = 1'b1;
        off_o[M8_OFF_W-1:0]    = addr_i[M8_OFF_W-1:0];
      end
      default: ;
    endcase
    swap_o  = be && size2_i;
    size2_o = size2_i && (win_i == WIN_REGS || win_i == WIN_MEM16);
  end
endmodule

// File: rtl/carrier_addr_dec.sv
module carrier_addr_dec
  import carrier_pkg::*;
#(
  parameter int N_SLOTS   = 4,
  parameter int DW        = 16,
  parameter int M16_OFF_W = 23,
  parameter int M8_OFF_W  = 22,
  parameter int CFG_AW    = 7,
  localparam int SLOT_W   = $clog2(N_SLOTS),
  localparam int AW       = M16_OFF_W + SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [1:0]           win_i,
  input  logic [AW-1:0]        addr_i,
  input  logic                 size2_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 ack_o,
  output logic [DW-1:0]        rdata_o,
  input  logic [N_SLOTS-1:0]   present_i,
  output logic [N_SLOTS-1:0]   slot_sel_o,
  output logic [N_SPACES-1:0]  space_sel_o,
  output logic                 mod_we_o,
  output logic                 mod_size2_o,
  output logic [M16_OFF_W-1:0] mod_off_o,
  output logic [DW-1:0]        mod_wdata_o,
  input  logic [DW-1:0]        mod_rdata_i
);
  localparam int HB = DW / 2;

  win_t               win;
  logic [2:0]         flags;
  logic [7:0]         cfg_byte;
  logic               is_mod, swap, stb;
  logic [SLOT_W-1:0]  slot;
  logic [N_SPACES-1:0] space;
  logic [DW-1:0]      rd_next;

  assign win = win_t'(win_i);

  carrier_endian_cfg #(.N_FLAGS(3), .CFG_AW(CFG_AW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (req_i && we_i && win == WIN_CFG),
    .addr_i  (addr_i[CFG_AW-1:0]),
    .wbit_i  (wdata_i[0]),
    .flags_o (flags),
    .rbyte_o (cfg_byte)
  );

  carrier_win_decode #(
    .SLOT_W(SLOT_W), .M16_OFF_W(M16_OFF_W), .M8_OFF_W(M8_OFF_W)
  ) u_dec (
    .win_i     (win),
    .addr_i    (addr_i),
    .size2_i   (size2_i),
    .be_regs_i (flags[1]),
    .be_m16_i  (flags[2]),
    .is_mod_o  (is_mod),
    .slot_o    (slot),
    .space_o   (space),
    .off_o     (mod_off_o),
    .swap_o    (swap),
    .size2_o   (mod_size2_o)
  );

  assign stb         = req_i && is_mod && present_i[slot];
  assign slot_sel_o  = stb ? (N_SLOTS'(1) << slot) : '0;
  assign space_sel_o = stb ? space : '0;
  assign mod_we_o    = stb && we_i;
  assign mod_wdata_o = swap ? {wdata_i[HB-1:0], wdata_i[DW-1:HB]} : wdata_i;

  always_comb begin
    if (win == WIN_CFG)  rd_next = DW'(cfg_byte);
    else if (!stb)       rd_next = '0;
    else if (swap)       rd_next = {mod_rdata_i[HB-1:0], mod_rdata_i[DW-1:HB]};
    else                 rd_next = mod_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= (req_i && !we_i) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/carrier_addr_dec_chk.sv
module carrier_addr_dec_chk
  import carrier_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DW      = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [1:0]          win_i,
  input logic [DW-1:0]       wdata_i,
  input logic [N_SLOTS-1:0]  present_i,
  input logic [N_SLOTS-1:0]  slot_sel_o,
  input logic [N_SPACES-1:0] space_sel_o,
  input logic                mod_we_o,
  input logic                mod_size2_o,
  input logic [DW-1:0]       mod_wdata_o,
  input logic                ack_o,
  input logic [DW-1:0]       rdata_o
);
  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_sel_o) && $onehot0(space_sel_o)); // R4
  AST_SEL_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_o != '0) == (space_sel_o != '0)); // R4
  AST_STB_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (slot_sel_o == '0) && !mod_we_o); // R4
  AST_WE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_we_o |-> we_i && slot_sel_o != '0); // R4
  AST_ABSENT_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_o & ~present_i) == '0); // R5
  AST_ABSENT_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && win_i != WIN_CFG && present_i == '0 |=> rdata_o == '0); // R5
  AST_ACK_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o); // R6
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o); // R6
  AST_MEM8_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_sel_o != '0 && win_i == WIN_MEM8 |-> mod_wdata_o == wdata_i && !mod_size2_o); // R9
  AST_CFG_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win_i == WIN_CFG |-> slot_sel_o == '0); // R10
endmodule

bind carrier_addr_dec carrier_addr_dec_chk #(.N_SLOTS(N_SLOTS), .DW(DW)) u_chk (.*);

// File: tb/carrier_addr_dec_bench.sv
`timescale 1ns/1ps
module carrier_addr_dec_bench;
  localparam int AW = 25;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, size2 = 0;
  logic [1:0]  win = 0;
  logic [AW-1:0] addr = 0;
  logic [15:0] wdata = 0, mod_rdata = 16'h12C4;
  logic [3:0]  present = 4'hF;
  logic        ack_o, mod_we_o, mod_size2_o;
  logic [15:0] rdata_o, mod_wdata_o;
  logic [3:0]  slot_sel_o;
  logic [4:0]  space_sel_o;
  logic [22:0] mod_off_o;

  int nchk = 0, nerr = 0;
  logic [3:0]  c_slot;
  logic [4:0]  c_space;
  logic [22:0] c_off;
  logic [15:0] c_wd, c_rd;
  logic        c_we, c_s2, c_ack;

  always #2.5 clk = ~clk;

  carrier_addr_dec u_carrier_addr_dec (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .win_i(win),
    .addr_i(addr), .size2_i(size2), .wdata_i(wdata), .ack_o(ack_o),
    .rdata_o(rdata_o), .present_i(present), .slot_sel_o(slot_sel_o),
    .space_sel_o(space_sel_o), .mod_we_o(mod_we_o), .mod_size2_o(mod_size2_o),
    .mod_off_o(mod_off_o), .mod_wdata_o(mod_wdata_o), .mod_rdata_i(mod_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] w, input logic wr, input logic [AW-1:0] a,
                     input logic s2, input logic [15:0] wd);
    @(negedge clk);
    req = 1; win = w; we = wr; addr = a; size2 = s2; wdata = wd;
    #1;
    c_slot = slot_sel_o; c_space = space_sel_o; c_off = mod_off_o;
    c_wd = mod_wdata_o; c_we = mod_we_o; c_s2 = mod_size2_o;
    @(negedge clk);
    req = 0; we = 0;
    c_ack = ack_o; c_rd = rdata_o;
  endtask

  task automatic t_reset;
    chk("R1 ack after reset", ack_o, 0);
    chk("R1 rdata after reset", rdata_o, 0);
    acc(0, 0, 'h2B, 0, 0); chk("R1 R10 flag0 read", c_rd, 16'h00D4);
    acc(0, 0, 'h2F, 0, 0); chk("R1 R10 flag1 read", c_rd, 16'h0014);
    acc(0, 0, 'h33, 0, 0); chk("R1 R10 flag2 read", c_rd, 16'h0014);
    chk("R10 cfg no strobe", c_slot, 0);
  endtask

  task automatic t_regs;
    acc(1, 0, 'h29D, 0, 0);
    chk("R2 id slot", c_slot, 4'b0100); chk("R2 id space", c_space, 5'b00010);
    chk("R2 id off", c_off, 'h1D);
    chk("R6 ack", c_ack, 1); chk("R6 read data", c_rd, 16'h12C4);
    acc(1, 0, 'h1C5, 0, 0);
    chk("R2 int slot", c_slot, 4'b0010); chk("R2 int space", c_space, 5'b00100);
    chk("R2 int off", c_off, 'h05);
    acc(1, 1, 'h36A, 1, 16'hBEEF);
    chk("R2 io slot", c_slot, 4'b1000); chk("R2 io space", c_space, 5'b00001);
    chk("R2 io off", c_off, 'h6A);
    chk("R4 write strobe", c_we, 1); chk("R4 wdata", c_wd, 16'hBEEF);
    chk("R6 rdata after write", c_rd, 0);
  endtask

  task automatic t_mem;
    acc(2, 0, (25'd1 << 23) | 25'h123456, 1, 0);
    chk("R3 m16 slot", c_slot, 4'b0010); chk("R3 m16 space", c_space, 5'b01000);
    chk("R3 m16 off", c_off, 'h123456);
    acc(3, 0, 25'h1EABCDE, 0, 0);
    chk("R3 m8 slot", c_slot, 4'b1000); chk("R3 m8 space", c_space, 5'b10000);
    chk("R3 m8 off", c_off, 'h2ABCDE);
  endtask

  task automatic t_absent;
    present = 4'b1011;
    acc(1, 0, 'h29D, 0, 0);
    chk("R5 absent no slot", c_slot, 0); chk("R5 absent no space", c_space, 0);
    chk("R5 absent read zero", c_rd, 0); chk("R6 absent ack", c_ack, 1);
    acc(2, 1, (25'd2 << 23), 1, 16'h5555);
    chk("R5 absent no write", c_we, 0);
    acc(1, 0, 'h19D, 0, 0);
    chk("R5 neighbour present", c_slot, 4'b0010);
    present = 4'hF;
  endtask

  task automatic t_endian;
    acc(0, 1, 'h2F, 0, 16'h0001);
    acc(0, 0, 'h2F, 0, 0); chk("R10 flag1 set", c_rd, 16'h0015);
    acc(1, 0, 'h29D, 0, 0); chk("R7 byte flip off", c_off, 'h1C);
    acc(1, 0, 'h2BF, 0, 0); chk("R7 flip crosses", c_off, 'h3E);
    acc(1, 1, 'h29C, 1, 16'hBEEF);
    chk("R8 wdata swap", c_wd, 16'hEFBE); chk("R8 size2", c_s2, 1);
    chk("R7 halfword no flip", c_off, 'h1C);
    acc(1, 0, 'h29C, 1, 0); chk("R8 rdata swap", c_rd, 16'hC412);
    acc(2, 0, (25'd1 << 23) | 25'h10, 1, 0); chk("R8 m16 not swapped", c_rd, 16'h12C4);
    acc(2, 0, (25'd1 << 23) | 25'h10, 0, 0); chk("R7 m16 not flipped", c_off, 'h10);
    acc(0, 1, 'h33, 0, 16'h00FF);
    acc(0, 1, 'h2B, 0, 16'h0001);
    acc(0, 0, 'h2B, 0, 0); chk("R10 flag0 set", c_rd, 16'h00D5);
    acc(2, 0, (25'd1 << 23) | 25'h10, 0, 0); chk("R7 m16 flipped", c_off, 'h11);
    acc(2, 0, (25'd1 << 23) | 25'h10, 1, 0); chk("R8 m16 swapped", c_rd, 16'hC412);
    acc(3, 1, 25'h0000001, 1, 16'hBEEF);
    chk("R9 m8 data raw", c_wd, 16'hBEEF); chk("R9 m8 byte", c_s2, 0);
    chk("R9 m8 off raw", c_off, 'h1);
    acc(3, 0, 25'h0000001, 1, 0); chk("R9 m8 rdata raw", c_rd, 16'h12C4);
    acc(0, 1, 'h2C, 0, 16'h0001);
    acc(0, 0, 'h2C, 0, 0); chk("R10 other byte zero", c_rd, 0);
    acc(0, 0, 'h2F, 0, 0); chk("R10 other write no effect", c_rd, 16'h0015);
    acc(0, 1, 'h2F, 0, 16'h00FE);
    acc(0, 0, 'h2F, 0, 0); chk("R10 flag1 cleared", c_rd, 16'h0014);
    acc(1, 0, 'h29D, 0, 0); chk("R7 cleared no flip", c_off, 'h1D);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #12; rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_mem;
    t_absent;
    t_endian;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule